// File: doc/BRIEF.md
# Magnitude Threshold Detector with Dwell Hysteresis

This block watches one or more streams of signed two's complement converter samples and raises a per-channel warning flag when a sample's size comes close to full scale, early enough for an external gain stage to back off before clipping. Only the size of each sample counts. A sample of +x and a sample of -x produce the same flag behaviour.

The flag sets through a short fixed pipeline when a magnitude exceeds a coarse upper threshold. The upper threshold is a 4-bit fraction of full scale in steps of one eighth. Release is time qualified. The flag drops only after a run of consecutive valid samples has stayed under a fine 15-bit lower threshold for a programmed dwell count. Any valid sample at or above the lower threshold restarts that run.

The channels share the thresholds, the dwell count and the enable. Each channel has its own sample input, valid strobe, dwell counter and flag. The configuration values are meant to be held static while samples are in flight.

Top module: `mag_thresh_detect`

## Requirements
- R1: A synchronous reset clears every flag, every dwell counter and every sample in flight. A sample captured up to the reset edge never sets a flag after reset.
- R2: The magnitude of a sample is its absolute value as a 15-bit number. The most negative code, -32768, counts as 32767. Samples +x and -x set the flag identically on both channels.
- R3: A valid sample sets its channel's flag only when its magnitude is strictly greater than the upper threshold value shifted left by 12 bits. With a threshold of 4, a magnitude of 16384 does not set the flag and 16385 does.
- R4: A sample captured at a rising edge shows its effect on the flag just after the seventh rising edge, counting the capture edge as the first. After the sixth edge the flag still shows the earlier state.
- R5: Once set, the flag clears at the decision of the Nth consecutive valid sample whose magnitude is below the lower threshold, where N is the dwell value.
- R6: A valid sample whose magnitude is at or above the lower threshold restarts the dwell run from zero, and the flag stays set.
- R7: A dwell value of 0 behaves as a dwell value of 1.
- R8: When enable is low, the flag and the dwell counter clear at the next rising edge and no crossing can set the flag. A crossing decided at an edge where enable is low is lost.
- R9: When one sample both exceeds the upper threshold and is below the lower threshold, setting wins. The flag stays set and the dwell run restarts.
- R10: The channels are independent. A crossing on one channel leaves the other channel's flag unchanged.
- R11: Samples with their valid strobe low neither set the flag, nor advance the dwell run, nor restart it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Feature enable; low clears all flags |
| upper_thr | input | 4 | Upper threshold in eighths of full scale |
| lower_thr | input | 15 | Lower threshold in full-resolution magnitude units |
| dwell_len | input | 16 | Consecutive below-lower samples needed to release; 0 acts as 1 |
| sample_valid | input | 2 | Per-channel sample strobe |
| sample_data | input | 32 | Per-channel signed samples, channel c in bits [16c+15:16c] |
| over_flag | output | 2 | Per-channel overrange flag |

## Verification
Two functions can fall on the same sample decision. One is setting on an upper crossing. The other is dwell completion when a sample sits under the lower threshold. They coincide when the lower threshold is programmed above the scaled upper threshold. The bench provokes this with an upper threshold of one eighth, a lower threshold near 61 percent and a dwell of 1, then feeds samples between the two levels. It requires the flag to stay high for as long as such samples keep arriving, then to drop exactly one decision after the first small sample. A second collision drops enable on the very edge that decides an upper crossing and expects the crossing to be lost. Random streams with changing thresholds are checked every cycle against a reference model in the bench.

// File: rtl/mtd_pkg.sv
package mtd_pkg;

   // Result of the compare stage, carried down the delay line.
   typedef struct packed {
      logic valid;
      logic over_up;
      logic under_lo;
   } mtd_cmp_t;

   // Per-channel flag state.
   typedef enum logic {
      ST_CLEAR = 1'b0,
      ST_HELD  = 1'b1
   } mtd_state_e;

endpackage

// File: rtl/mtd_magnitude.sv
// Input capture stage followed by a registered absolute value.
module mtd_magnitude #(
   parameter int SAMPLE_W  = 16,
   parameter bit ABS_EXACT = 1'b1,
   localparam int MAG_W    = SAMPLE_W - 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_data,
   output logic                mag_valid,
   output logic [MAG_W-1:0]    mag
);

   logic                s1_valid;
   logic [SAMPLE_W-1:0] s1_data;
   logic [MAG_W-1:0]    abs_c;

   if (SAMPLE_W < 4) begin : g_bad_width
      $error("mtd_magnitude: SAMPLE_W must be at least 4");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid <= 1'b0;
         s1_data  <= '0;
      end else begin
         s1_valid <= in_valid;
         s1_data  <= in_data;
      end
   end

   if (ABS_EXACT) begin : g_abs_exact
      // Two's complement negate, most negative code saturated.
      logic [SAMPLE_W-1:0] neg_v;
      always_comb begin
         neg_v = -s1_data;
         if (!s1_data[SAMPLE_W-1]) begin
            abs_c = s1_data[MAG_W-1:0];
         end else if (neg_v[SAMPLE_W-1]) begin
            abs_c = '1;
         end else begin
            abs_c = neg_v[MAG_W-1:0];
         end
      end
   end else begin : g_abs_ones
      // One's complement: one LSB low for negatives, no carry chain.
      always_comb begin
         abs_c = s1_data[SAMPLE_W-1] ? ~s1_data[MAG_W-1:0] : s1_data[MAG_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mag_valid <= 1'b0;
         mag       <= '0;
      end else begin
         mag_valid <= s1_valid;
         mag       <= abs_c;
      end
   end

endmodule

// File: rtl/mtd_compare.sv
// Registered comparison against the scaled coarse and the fine threshold.
module mtd_compare
   import mtd_pkg::*;
#(
   parameter int MAG_W   = 15,
   parameter int UP_W    = 4,
   localparam int UP_SHIFT = MAG_W + 1 - UP_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mag_valid,
   input  logic [MAG_W-1:0] mag,
   input  logic [UP_W-1:0]  upper,
   input  logic [MAG_W-1:0] lower,
   output mtd_cmp_t         cmp
);

   logic [MAG_W:0] upper_scaled;
   mtd_cmp_t       cmp_c;

   if (UP_W < 1 || UP_W > MAG_W) begin : g_bad_upw
      $error("mtd_compare: UP_W must lie in 1..MAG_W");
   end

   always_comb begin
      upper_scaled   = {upper, {UP_SHIFT{1'b0}}};
      cmp_c.valid    = mag_valid;
      cmp_c.over_up  = mag_valid && ({1'b0, mag} > upper_scaled);
      cmp_c.under_lo = mag_valid && (mag < lower);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cmp <= '0;
      end else begin
         cmp <= cmp_c;
      end
   end

endmodule

// File: rtl/mtd_delay.sv
// Fixed-depth register delay line used to reach the required latency.
module mtd_delay #(
   parameter int W     = 3,
   parameter int DEPTH = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   if (DEPTH < 0) begin : g_bad_depth
      $error("mtd_delay: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_pass
      assign dout = din;
   end else begin : g_regs
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
         end else begin
            stg[0] <= din;
            for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
         end
      end
      assign dout = stg[DEPTH-1];
   end

endmodule

// File: rtl/mtd_hyst.sv
// Flag register with the restartable dwell timer.
module mtd_hyst
   import mtd_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enable,
   input  mtd_cmp_t         cmp,
   input  logic [CNT_W-1:0] dwell,
   output logic             flag
);

   mtd_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   cnt_next;
   logic [CNT_W:0]   dwell_eff;

   always_comb begin
      dwell_eff = (dwell == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, dwell};
      cnt_next  = {1'b0, cnt} + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst || !enable) begin
         state <= ST_CLEAR;
         cnt   <= '0;
      end else if (cmp.valid && cmp.over_up) begin
         state <= ST_HELD;
         cnt   <= '0;
      end else if (cmp.valid && state == ST_HELD) begin
         if (!cmp.under_lo) begin
            cnt <= '0;
         end else if (cnt_next >= dwell_eff) begin
            state <= ST_CLEAR;
            cnt   <= '0;
         end else begin
            cnt <= cnt_next[CNT_W-1:0];
         end
      end
   end

   assign flag = (state == ST_HELD);

endmodule

// File: rtl/mag_thresh_detect.sv
// Multi-channel magnitude threshold detector with time-qualified release.
module mag_thresh_detect
   import mtd_pkg::*;
#(
   parameter int NUM_CH    = 2,
   parameter int SAMPLE_W  = 16,
   parameter int UP_W      = 4,
   parameter int DWELL_W   = 16,
   parameter int LATENCY   = 7,
   parameter bit ABS_EXACT = 1'b1,
   localparam int MAG_W    = SAMPLE_W - 1,
   localparam int DLY      = LATENCY - 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       enable,
   input  logic [UP_W-1:0]            upper_thr,
   input  logic [MAG_W-1:0]           lower_thr,
   input  logic [DWELL_W-1:0]         dwell_len,
   input  logic [NUM_CH-1:0]          sample_valid,
   input  logic [NUM_CH*SAMPLE_W-1:0] sample_data,
   output logic [NUM_CH-1:0]          over_flag
);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("mag_thresh_detect: NUM_CH must be at least 1");
   end
   if (LATENCY < 4) begin : g_bad_lat
      $error("mag_thresh_detect: LATENCY must be at least 4");
   end
   if (DWELL_W < 1) begin : g_bad_dwell
      $error("mag_thresh_detect: DWELL_W must be at least 1");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic             mag_valid;
      logic [MAG_W-1:0] mag;
      mtd_cmp_t         cmp_now;
      mtd_cmp_t         cmp_late;

      mtd_magnitude #(
         .SAMPLE_W  (SAMPLE_W),
         .ABS_EXACT (ABS_EXACT)
      ) i_mag (
         .clk       (clk),
         .rst       (rst),
         .in_valid  (sample_valid[c]),
         .in_data   (sample_data[c*SAMPLE_W +: SAMPLE_W]),
         .mag_valid (mag_valid),
         .mag       (mag)
      );

      mtd_compare #(
         .MAG_W (MAG_W),
         .UP_W  (UP_W)
      ) i_cmp (
         .clk       (clk),
         .rst       (rst),
         .mag_valid (mag_valid),
         .mag       (mag),
         .upper     (upper_thr),
         .lower     (lower_thr),
         .cmp       (cmp_now)
      );

      mtd_delay #(
         .W     ($bits(mtd_cmp_t)),
         .DEPTH (DLY)
      ) i_dly (
         .clk  (clk),
         .rst  (rst),
         .din  (cmp_now),
         .dout (cmp_late)
      );

      mtd_hyst #(
         .CNT_W (DWELL_W)
      ) i_hyst (
         .clk    (clk),
         .rst    (rst),
         .enable (enable),
         .cmp    (cmp_late),
         .dwell  (dwell_len),
         .flag   (over_flag[c])
      );
   end

endmodule

// File: rtl/mtd_checker.sv
// Temporal checks on the detector ports, attached by bind.
module mtd_checker #(
   parameter int NUM_CH   = 2,
   parameter int SAMPLE_W = 16,
   parameter int UP_W     = 4,
   parameter int LATENCY  = 7,
   localparam int MAG_W   = SAMPLE_W - 1,
   localparam int SHIFT   = MAG_W + 1 - UP_W
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       enable,
   input logic [UP_W-1:0]            upper_thr,
   input logic [NUM_CH-1:0]          sample_valid,
   input logic [NUM_CH*SAMPLE_W-1:0] sample_data,
   input logic [NUM_CH-1:0]          over_flag
);

   logic [NUM_CH-1:0] cross_now;
   logic [NUM_CH-1:0] hist [LATENCY-1];

   always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
         logic [SAMPLE_W-1:0] s;
         logic [MAG_W:0]      m;
         s = sample_data[c*SAMPLE_W +: SAMPLE_W];
         if (!s[SAMPLE_W-1])            m = {1'b0, s[MAG_W-1:0]};
         else if (s[MAG_W-1:0] == '0)   m = {1'b0, {MAG_W{1'b1}}};
         else                           m = {1'b0, ((~s[MAG_W-1:0]) + 1'b1)};
         cross_now[c] = sample_valid[c] && (m > {upper_thr, {SHIFT{1'b0}}});
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < LATENCY - 1; k++) hist[k] <= '0;
      end else begin
         hist[0] <= cross_now;
         for (int k = 1; k < LATENCY - 1; k++) hist[k] <= hist[k-1];
      end
   end

   // R1: reset empties the flags at the next edge.
   p_reset_clears_r1: assert property (@(posedge clk)
      rst |=> (over_flag == '0));

   // R8: a low enable clears all flags at the next edge.
   p_disable_clears_r8: assert property (@(posedge clk) disable iff (rst)
      !enable |=> (over_flag == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R4: a crossing sets the flag exactly at its seventh edge.
      p_cross_sets_flag_r4: assert property (@(posedge clk) disable iff (rst)
         (hist[LATENCY-2][c] && enable) |=> over_flag[c]);

      // R3: the flag only rises from a sample above the scaled upper threshold.
      p_rise_needs_cross_r3: assert property (@(posedge clk) disable iff (rst)
         $rose(over_flag[c]) |-> $past(hist[LATENCY-2][c]));
   end

endmodule

bind mag_thresh_detect mtd_checker #(
   .NUM_CH   (NUM_CH),
   .SAMPLE_W (SAMPLE_W),
   .UP_W     (UP_W),
   .LATENCY  (LATENCY)
) i_mtd_checker (
   .clk          (clk),
   .rst          (rst),
   .enable       (enable),
   .upper_thr    (upper_thr),
   .sample_valid (sample_valid),
   .sample_data  (sample_data),
   .over_flag    (over_flag)
);

// File: tb/test_mag_thresh_detect.sv
module test_mag_thresh_detect;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        enable = 1'b1;
   logic [3:0]  upper_thr = 4'd4;
   logic [14:0] lower_thr = 15'd13107;
   logic [15:0] dwell_len = 16'd3;
   logic [1:0]  sample_valid = '0;
   logic [31:0] sample_data = '0;
   logic [1:0]  over_flag;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   int  h_s [NCH][7];
   bit  h_v [NCH][7];
   bit  m_flag [NCH];
   int  m_cnt  [NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   mag_thresh_detect i_mag_thresh_detect (
      .clk          (clk),
      .rst          (rst),
      .enable       (enable),
      .upper_thr    (upper_thr),
      .lower_thr    (lower_thr),
      .dwell_len    (dwell_len),
      .sample_valid (sample_valid),
      .sample_data  (sample_data),
      .over_flag    (over_flag)
   );

   function automatic int mag_of(logic [15:0] s);
      int v;
      v = int'($signed(s));
      if (v < 0) v = -v;
      if (v > 32767) v = 32767;
      return v;
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Reference decision for one channel, using the sample from six edges back.
   task automatic model_step(int c);
      int eff;
      int s;
      bit v;
      eff = (dwell_len == 0) ? 1 : int'(dwell_len);
      s = h_s[c][6];
      v = h_v[c][6];
      if (!enable) begin
         m_flag[c] = 1'b0;
         m_cnt[c]  = 0;
      end else if (v && s > (int'(upper_thr) << 12)) begin
         m_flag[c] = 1'b1;
         m_cnt[c]  = 0;
      end else if (v && m_flag[c]) begin
         if (s < int'(lower_thr)) begin
            if (m_cnt[c] + 1 >= eff) begin
               m_flag[c] = 1'b0;
               m_cnt[c]  = 0;
            end else begin
               m_cnt[c] = m_cnt[c] + 1;
            end
         end else begin
            m_cnt[c] = 0;
         end
      end
   endtask

   task automatic tick();
      @(posedge clk);
      for (int c = 0; c < NCH; c++) begin
         for (int k = 6; k > 0; k--) begin
            h_s[c][k] = h_s[c][k-1];
            h_v[c][k] = h_v[c][k-1];
         end
         h_s[c][0] = mag_of(sample_data[c*16 +: 16]);
         h_v[c][0] = sample_valid[c];
         if (rst) begin
            for (int k = 0; k < 7; k++) begin
               h_s[c][k] = 0;
               h_v[c][k] = 1'b0;
            end
            m_flag[c] = 1'b0;
            m_cnt[c]  = 0;
         end else begin
            model_step(c);
         end
      end
      #1;
      for (int c = 0; c < NCH; c++) begin
         check($sformatf("R5 model ch%0d", c), int'(over_flag[c]), int'(m_flag[c]));
      end
   endtask

   task automatic drive(int s0, int s1, bit v);
      sample_data[15:0]  = s0[15:0];
      sample_data[31:16] = s1[15:0];
      sample_valid       = {v, v};
      tick();
   endtask

   task automatic pulse(int s0, int s1, int fill, bit fv);
      drive(s0, s1, 1'b1);
      repeat (6) drive(fill, fill, fv);
   endtask

   task automatic set_cfg(int u, int l, int d);
      repeat (7) drive(0, 0, 1'b0);
      upper_thr = u[3:0];
      lower_thr = l[14:0];
      dwell_len = d[15:0];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int q [12];
      void'($urandom(32'd20240611));
      for (int c = 0; c < NCH; c++) begin
         m_flag[c] = 1'b0;
         m_cnt[c]  = 0;
         for (int k = 0; k < 7; k++) begin
            h_s[c][k] = 0;
            h_v[c][k] = 1'b0;
         end
      end

      // R1: reset state
      repeat (4) drive(0, 0, 1'b0);
      check("R1 reset ch0", int'(over_flag[0]), 0);
      check("R1 reset ch1", int'(over_flag[1]), 0);
      rst = 1'b0;

      // R4, R5, R10: latency, release after dwell, channel isolation
      set_cfg(4, 13107, 3);
      drive(20000, 0, 1'b1);
      repeat (5) drive(0, 0, 1'b1);
      check("R4 not yet at sixth edge", int'(over_flag[0]), 0);
      drive(0, 0, 1'b1);
      check("R4 set at seventh edge", int'(over_flag[0]), 1);
      check("R10 other channel untouched", int'(over_flag[1]), 0);
      repeat (2) drive(0, 0, 1'b1);
      check("R5 held before dwell ends", int'(over_flag[0]), 1);
      drive(0, 0, 1'b1);
      check("R5 cleared at dwell end", int'(over_flag[0]), 0);

      // R3: strict comparison against threshold << 12
      pulse(16384, 16384, 0, 1'b1);
      check("R3 equal does not set ch0", int'(over_flag[0]), 0);
      check("R3 equal does not set ch1", int'(over_flag[1]), 0);
      pulse(16385, 0, 0, 1'b1);
      check("R3 one above sets", int'(over_flag[0]), 1);
      repeat (3) drive(0, 0, 1'b1);
      check("R3 released", int'(over_flag[0]), 0);

      // R2: sign blind, most negative code saturates
      pulse(20000, -20000, 0, 1'b1);
      check("R2 positive ch0", int'(over_flag[0]), 1);
      check("R2 negative ch1", int'(over_flag[1]), 1);
      repeat (3) drive(0, 0, 1'b1);
      check("R2 both release ch1", int'(over_flag[1]), 0);
      set_cfg(7, 13107, 3);
      pulse(-32768, 32767, 0, 1'b1);
      check("R2 most negative sets ch0", int'(over_flag[0]), 1);
      check("R2 max positive sets ch1", int'(over_flag[1]), 1);
      repeat (3) drive(0, 0, 1'b1);
      check("R2 most negative releases", int'(over_flag[0]), 0);

      // R6: restart of the dwell run
      set_cfg(4, 13107, 3);
      pulse(20000, 0, 15000, 1'b1);
      check("R6 set", int'(over_flag[0]), 1);
      q = '{0, 0, 15000, 0, 0, 0, 0, 0, 0, 0, 0, 0};
      for (int i = 0; i < 11; i++) drive(q[i], 0, 1'b1);
      check("R6 restart keeps flag", int'(over_flag[0]), 1);
      drive(q[11], 0, 1'b1);
      check("R6 clear after full run", int'(over_flag[0]), 0);

      // R7: dwell of zero acts as one
      set_cfg(4, 13107, 0);
      pulse(20000, 0, 15000, 1'b1);
      repeat (6) drive(0, 0, 1'b1);
      check("R7 held while above lower", int'(over_flag[0]), 1);
      drive(0, 0, 1'b1);
      check("R7 one sample releases", int'(over_flag[0]), 0);

      // R8: enable clears, and beats a crossing on the same edge
      set_cfg(4, 13107, 3);
      pulse(20000, 0, 15000, 1'b1);
      check("R8 set before disable", int'(over_flag[0]), 1);
      enable = 1'b0;
      drive(15000, 0, 1'b1);
      check("R8 disable clears", int'(over_flag[0]), 0);
      enable = 1'b1;
      set_cfg(4, 13107, 3);
      drive(20000, 0, 1'b1);
      repeat (5) drive(15000, 0, 1'b1);
      enable = 1'b0;
      drive(15000, 0, 1'b1);
      check("R8 crossing lost while disabled", int'(over_flag[0]), 0);
      enable = 1'b1;
      drive(15000, 0, 1'b1);
      check("R8 stays clear after re-enable", int'(over_flag[0]), 0);

      // R9: set beats dwell completion on the same decision
      set_cfg(1, 20000, 1);
      pulse(5000, 0, 5000, 1'b1);
      check("R9 set", int'(over_flag[0]), 1);
      drive(5000, 0, 1'b1);
      check("R9 set wins over release", int'(over_flag[0]), 1);
      repeat (6) drive(0, 0, 1'b1);
      check("R9 still held", int'(over_flag[0]), 1);
      drive(0, 0, 1'b1);
      check("R9 releases after small sample", int'(over_flag[0]), 0);

      // R11: invalid samples ignored
      set_cfg(4, 13107, 2);
      pulse(20000, 0, 0, 1'b0);
      repeat (20) drive(0, 0, 1'b0);
      check("R11 invalid does not count", int'(over_flag[0]), 1);
      repeat (7) drive(0, 0, 1'b1);
      check("R11 one valid below", int'(over_flag[0]), 1);
      drive(0, 0, 1'b1);
      check("R11 second valid releases", int'(over_flag[0]), 0);
      drive(30000, 30000, 1'b0);
      repeat (6) drive(0, 0, 1'b0);
      check("R11 invalid large no set ch0", int'(over_flag[0]), 0);
      check("R11 invalid large no set ch1", int'(over_flag[1]), 0);

      // R1: in-flight sample discarded by reset
      drive(20000, 0, 1'b1);
      drive(0, 0, 1'b1);
      rst = 1'b1;
      drive(0, 0, 1'b0);
      rst = 1'b0;
      repeat (6) drive(0, 0, 1'b1);
      check("R1 in-flight sample dropped", int'(over_flag[0]), 0);

      // Random streams checked against the model every cycle (R5)
      for (int blk = 0; blk < 10; blk++) begin
         set_cfg(2 + int'($urandom % 6), 6000 + int'($urandom % 18000),
                 int'($urandom % 7));
         for (int i = 0; i < 400; i++) begin
            int s [2];
            for (int c = 0; c < 2; c++) begin
               int r;
               r = int'($urandom % 4);
               case (r)
                  0: s[c] = int'($urandom % 6000);
                  1: s[c] = 6000 + int'($urandom % 10000);
                  2: s[c] = 16000 + int'($urandom % 16768);
                  default: s[c] = 32767;
               endcase
               if ($urandom % 2 == 1) s[c] = -s[c] - ((r == 3) ? 1 : 0);
            end
            if (enable && ($urandom % 150 == 0)) enable = 1'b0;
            else if (!enable && ($urandom % 8 == 0)) enable = 1'b1;
            sample_data[15:0]  = s[0][15:0];
            sample_data[31:16] = s[1][15:0];
            sample_valid       = {($urandom % 10 != 0), ($urandom % 10 != 0)};
            tick();
         end
         enable = 1'b1;
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule